// File: doc/BRIEF.md
# DMA Channel Major-Loop Controller

This block holds the per-channel loop bookkeeping of a descriptor-driven DMA engine. Software programs a beginning iteration count, which also loads the current count. The engine reports when service of the channel starts, when each minor loop finishes and when an error occurs. Each finished minor loop lowers the current count by one. When the count runs out, the major loop is complete. At that point the block reloads the count, marks the channel done and carries out the completion actions that software selected.

Three completion actions are available. The first drops the channel's hardware request enable. The second sends a one-clock start pulse, tagged with a 6-bit target channel number, to a linked channel. The third asks the fetch logic to load the next 32-byte descriptor from a stored pointer. A sticky interrupt flag can be raised at the half-way point of the major loop, at completion, or at both. The data movement and the descriptor memory read happen outside this block.

Software reaches the block through a 2-bit-addressed write port. Address 0 is the control word. Address 1 loads the iteration count. Address 2 holds the descriptor pointer. Address 3 is a command word whose bits clear the status flags.

Top module: `dma_chan_major_ctl`

## Requirements
- R1: After reset, `done`, `active`, `irq`, `req_en`, `link_start`, `desc_fetch` and `cfg_err` are 0, and `citer` is 0.
- R2: A `svc_start` strobe sets `active` and clears `done`. A `minor_done` strobe clears `active`. An `eng_error` strobe clears `active` and leaves `citer` unchanged, even when `minor_done` arrives in the same cycle.
- R3: A write to address 1 loads bits [ITER_W-1:0] into both the beginning count and `citer`. Each `minor_done` lowers `citer` by one. When `citer` is 1, or is 0, the strobe completes the major loop: `citer` is reloaded with the beginning count and `done` is set one cycle later.
- R4: With control bit 0 (half interrupt enable) set, `irq` is set when a `minor_done` brings the count to the beginning count shifted right by one. Completion counts as 0 for this comparison, so a beginning count of 1 raises `irq` at completion.
- R5: With control bit 1 (completion interrupt enable) set, `irq` is set on completion. `irq` stays set until a write to address 3 with bit 0 set. Writes to address 3 with bit 0 clear leave it set.
- R6: At completion with control bit 2 (auto request disable) set, `req_en` is cleared. With bit 2 clear, `req_en` is left unchanged. `req_en` itself is written through control bit 5.
- R7: At completion with control bit 4 (link enable) set, `link_start` is high for one cycle. During that cycle `link_ch` carries the 6-bit target channel from control bits [11:6].
- R8: At completion with control bit 3 (descriptor reload enable) set, one of two things happens:
  - If the low 5 bits of the pointer are zero, `desc_fetch` pulses for one cycle and `desc_addr` shows the pointer.
  - Otherwise, `cfg_err` is set instead of the fetch. `cfg_err` stays set until a write to address 3 with bit 1 set.
- R9: A write to address 0 while `done` is set stores 0 in control bits 3 and 4, whatever value is written to them.
- R10: A write to address 3 with bit 2 set clears `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_addr | input | 2 | Register select: 0 control, 1 iteration count, 2 pointer, 3 command |
| sw_wr_data | input | 32 | Write data |
| svc_start | input | 1 | Engine begins servicing the channel |
| minor_done | input | 1 | Engine finished one minor loop |
| eng_error | input | 1 | Engine detected an error |
| req_en | output | 1 | Hardware request enable of the channel |
| done | output | 1 | Major loop complete flag |
| active | output | 1 | Channel in service flag |
| irq | output | 1 | Sticky channel interrupt |
| citer | output | ITER_W | Current iteration count |
| link_start | output | 1 | One-cycle start pulse to the linked channel |
| link_ch | output | 6 | Target channel of the link pulse |
| desc_fetch | output | 1 | One-cycle descriptor load request |
| desc_addr | output | PTR_W | Address of the next descriptor |
| cfg_err | output | 1 | Misaligned descriptor pointer seen at completion |

## Verification
The bench works through several boundary cases, each aimed at a specific wrong design:
- **Beginning count of 1 and of 0.** A design that decrements first and tests for zero afterwards would wrap the counter and never complete.
- **Half-way point for even and odd counts.** A shift in the wrong direction, or a comparison against the old count, moves the interrupt by one strobe.
- **Link or reload enable written while done is set.** A missing write guard lets a stale link fire on the next completion.
- **Misaligned pointer at completion.** A design that skips the alignment test would issue a fetch instead of raising the error.
- **Error in the same cycle as a minor completion.** This must not move the count.

// File: rtl/dma_major_pkg.sv
// Package: shared register selects, command bits and control word layout
// for the DMA channel major-loop controller.
package dma_major_pkg;
    localparam int LINK_W     = 6;
    localparam int ALIGN_BITS = 5;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_ITER  = 2'd1,
        REG_SGPTR = 2'd2,
        REG_CMD   = 2'd3
    } reg_sel_e;

    localparam int CMD_CLR_IRQ  = 0;
    localparam int CMD_CLR_ERR  = 1;
    localparam int CMD_CLR_DONE = 2;

    // Control word, LSB first: half_ie(0) major_ie(1) auto_dis(2) sg_en(3)
    // link_en(4) req_en(5) link_ch(11:6)
    typedef struct packed {
        logic [LINK_W-1:0] link_ch;
        logic              req_en;
        logic              link_en;
        logic              sg_en;
        logic              auto_dis;
        logic              major_ie;
        logic              half_ie;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dma_major_cfg_regs.sv
// Module: control word and descriptor pointer registers.
// Guards the link and reload enables against writes while done is set;
// hardware may clear the request enable at completion (wins over a write).
// Assumes a single-cycle write strobe with a decoded select.
module dma_major_cfg_regs
    import dma_major_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_wr,
    input  logic                 ptr_wr,
    input  logic [CTRL_W-1:0]    ctrl_wdata,
    input  logic [PTR_W-1:0]     ptr_wdata,
    input  logic                 done,
    input  logic                 req_clr,
    output ctrl_t                ctrl,
    output logic [PTR_W-1:0]     sg_ptr
);
    ctrl_t wr_word;

    // Purpose: mask the guarded enables when the loop is flagged done.
    always_comb begin
        wr_word         = ctrl_t'(ctrl_wdata);
        wr_word.link_en = wr_word.link_en & ~done;
        wr_word.sg_en   = wr_word.sg_en & ~done;
    end

    // Purpose: hold the control word, with completion clear of req_en.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (ctrl_wr) ctrl <= wr_word;
            if (req_clr) ctrl.req_en <= 1'b0;
        end
    end

    // Purpose: hold the next-descriptor pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)      sg_ptr <= '0;
        else if (ptr_wr) sg_ptr <= ptr_wdata;
    end
endmodule

// File: rtl/dma_major_iter_ctr.sv
// Module: beginning and current iteration counters.
// Flags completion by look-ahead (count of 1 or 0) so the counter never wraps,
// and compares the next count with half the beginning count.
// Assumes step is already qualified by the absence of an engine error.
module dma_major_iter_ctr #(
    parameter int ITER_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ITER_W-1:0] load_val,
    input  logic              step,
    output logic [ITER_W-1:0] citer,
    output logic              complete,
    output logic              half_hit
);
    logic [ITER_W-1:0] biter;
    logic [ITER_W-1:0] next_cnt;

    // Purpose: decide completion and the count after this step.
    always_comb begin
        complete = (citer <= ITER_W'(1));
        next_cnt = complete ? '0 : citer - ITER_W'(1);
        half_hit = (next_cnt == (biter >> 1));
    end

    // Purpose: load from software, count down, reload at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            biter <= '0;
            citer <= '0;
        end else if (load) begin
            biter <= load_val;
            citer <= load_val;
        end else if (step) begin
            citer <= complete ? biter : next_cnt;
        end
    end
endmodule

// File: rtl/dma_major_status.sv
// Module: status flags and completion pulses.
// Keeps done, active, the sticky interrupt and the configuration error, and
// issues the registered one-cycle link and descriptor-fetch pulses.
// Assumes major is step qualified by completion.
module dma_major_status
    import dma_major_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             svc_start,
    input  logic             minor_done,
    input  logic             eng_error,
    input  logic             step,
    input  logic             major,
    input  logic             half_hit,
    input  ctrl_t            ctrl,
    input  logic [PTR_W-1:0] sg_ptr,
    input  logic             clr_done,
    input  logic             clr_irq,
    input  logic             clr_err,
    output logic             done,
    output logic             active,
    output logic             irq,
    output logic             link_pulse,
    output logic             fetch_pulse,
    output logic             cfg_err
);
    logic aligned;
    logic irq_set;

    // Purpose: evaluate pointer alignment and interrupt causes.
    always_comb begin
        aligned = (sg_ptr[ALIGN_BITS-1:0] == '0);
        irq_set = (step && ctrl.half_ie && half_hit) || (major && ctrl.major_ie);
    end

    // Purpose: done flag, set at completion, cleared by start or command.
    always_ff @(posedge clk) begin
        if (!rst_n)         done <= 1'b0;
        else if (svc_start) done <= 1'b0;
        else if (major)     done <= 1'b1;
        else if (clr_done)  done <= 1'b0;
    end

    // Purpose: active flag across one minor loop.
    always_ff @(posedge clk) begin
        if (!rst_n)          active <= 1'b0;
        else if (eng_error)  active <= 1'b0;
        else if (svc_start)  active <= 1'b1;
        else if (minor_done) active <= 1'b0;
    end

    // Purpose: sticky interrupt and configuration error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            if (irq_set)      irq <= 1'b1;
            else if (clr_irq) irq <= 1'b0;
            if (major && ctrl.sg_en && !aligned) cfg_err <= 1'b1;
            else if (clr_err)                    cfg_err <= 1'b0;
        end
    end

    // Purpose: single-cycle completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_pulse  <= 1'b0;
            fetch_pulse <= 1'b0;
        end else begin
            link_pulse  <= major && ctrl.link_en;
            fetch_pulse <= major && ctrl.sg_en && aligned;
        end
    end
endmodule

// File: rtl/dma_chan_major_ctl.sv
// Module: top of the DMA channel major-loop controller.
// Decodes the software write port, wires counter, registers and status.
// Assumes sw_wr_data is at least as wide as ITER_W and PTR_W.
module dma_chan_major_ctl
    import dma_major_pkg::*;
#(
    parameter int ITER_W = 15,
    parameter int PTR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr_en,
    input  logic [1:0]        sw_wr_addr,
    input  logic [31:0]       sw_wr_data,
    input  logic              svc_start,
    input  logic              minor_done,
    input  logic              eng_error,
    output logic              req_en,
    output logic              done,
    output logic              active,
    output logic              irq,
    output logic [ITER_W-1:0] citer,
    output logic              link_start,
    output logic [LINK_W-1:0] link_ch,
    output logic              desc_fetch,
    output logic [PTR_W-1:0]  desc_addr,
    output logic              cfg_err
);
    reg_sel_e   wr_sel;
    ctrl_t      ctrl;
    logic       ctrl_wr, iter_wr, ptr_wr, cmd_wr;
    logic       step, complete, half_hit, major;
    logic [PTR_W-1:0] sg_ptr;

    // Purpose: decode writes and qualify the engine strobes.
    always_comb begin
        wr_sel  = reg_sel_e'(sw_wr_addr);
        ctrl_wr = sw_wr_en && (wr_sel == REG_CTRL);
        iter_wr = sw_wr_en && (wr_sel == REG_ITER);
        ptr_wr  = sw_wr_en && (wr_sel == REG_SGPTR);
        cmd_wr  = sw_wr_en && (wr_sel == REG_CMD);
        step    = minor_done && !eng_error;
        major   = step && complete;
    end

    dma_major_iter_ctr #(.ITER_W(ITER_W)) iter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (iter_wr),
        .load_val (sw_wr_data[ITER_W-1:0]),
        .step     (step),
        .citer    (citer),
        .complete (complete),
        .half_hit (half_hit)
    );

    dma_major_cfg_regs #(.PTR_W(PTR_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ptr_wr     (ptr_wr),
        .ctrl_wdata (sw_wr_data[CTRL_W-1:0]),
        .ptr_wdata  (sw_wr_data[PTR_W-1:0]),
        .done       (done),
        .req_clr    (major && ctrl.auto_dis),
        .ctrl       (ctrl),
        .sg_ptr     (sg_ptr)
    );

    dma_major_status #(.PTR_W(PTR_W)) stat_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .svc_start   (svc_start),
        .minor_done  (minor_done),
        .eng_error   (eng_error),
        .step        (step),
        .major       (major),
        .half_hit    (half_hit),
        .ctrl        (ctrl),
        .sg_ptr      (sg_ptr),
        .clr_done    (cmd_wr && sw_wr_data[CMD_CLR_DONE]),
        .clr_irq     (cmd_wr && sw_wr_data[CMD_CLR_IRQ]),
        .clr_err     (cmd_wr && sw_wr_data[CMD_CLR_ERR]),
        .done        (done),
        .active      (active),
        .irq         (irq),
        .link_pulse  (link_start),
        .fetch_pulse (desc_fetch),
        .cfg_err     (cfg_err)
    );

    // Purpose: expose request enable, link target and descriptor address.
    always_comb begin
        req_en    = ctrl.req_en;
        link_ch   = ctrl.link_ch;
        desc_addr = sg_ptr;
    end
endmodule

// File: rtl/dma_major_ctl_chk.sv
// Module: port-level checker for the major-loop controller, bound to the top.
// Assumes the synchronous active-low reset of the design.
module dma_major_ctl_chk #(
    parameter int PTR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_wr_en,
    input logic [1:0]       sw_wr_addr,
    input logic [31:0]      sw_wr_data,
    input logic             minor_done,
    input logic             eng_error,
    input logic             req_en,
    input logic             done,
    input logic             active,
    input logic             irq,
    input logic             link_start,
    input logic             desc_fetch,
    input logic [PTR_W-1:0] desc_addr,
    input logic             cfg_err
);
    // R2: active only drops after a minor completion or an error
    assert_active_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> $past(minor_done || eng_error));

    // R3: done only rises after a minor completion
    assert_done_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(minor_done && !eng_error));

    // R5: interrupt holds unless software writes its clear bit
    assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(sw_wr_en && sw_wr_addr == 2'd3 && sw_wr_data[0])) |=> irq);

    // R6: request enable drops only on completion or a software write
    assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_en) |-> $past(minor_done || sw_wr_en));

    // R7: link pulse follows an error-free minor completion
    assert_link_from_minor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        link_start |-> $past(minor_done && !eng_error));

    // R8: fetch only for an aligned pointer, never together with a new error
    assert_fetch_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        desc_fetch |-> ($past(desc_addr[4:0]) == 5'd0));
    assert_err_no_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> !desc_fetch);
endmodule

bind dma_chan_major_ctl dma_major_ctl_chk #(.PTR_W(PTR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_addr (sw_wr_addr),
    .sw_wr_data (sw_wr_data),
    .minor_done (minor_done),
    .eng_error  (eng_error),
    .req_en     (req_en),
    .done       (done),
    .active     (active),
    .irq        (irq),
    .link_start (link_start),
    .desc_fetch (desc_fetch),
    .desc_addr  (desc_addr),
    .cfg_err    (cfg_err)
);

// File: tb/dma_chan_major_ctl_tb_top.sv
// Bench: vector table of count/interrupt cases, then directed tests.
module dma_chan_major_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ITER_W = 15;
    localparam int PTR_W  = 32;
    localparam int NV = 8;

    // {beginning count[15:0], strobes[7:0], exp citer[15:0], exp done, exp irq}
    localparam logic [41:0] VEC [NV] = '{
        {16'd6, 8'd1, 16'd5, 1'b0, 1'b0},
        {16'd6, 8'd3, 16'd3, 1'b0, 1'b1},
        {16'd6, 8'd6, 16'd6, 1'b1, 1'b1},
        {16'd6, 8'd5, 16'd1, 1'b0, 1'b1},
        {16'd1, 8'd1, 16'd1, 1'b1, 1'b1},
        {16'd4, 8'd2, 16'd2, 1'b0, 1'b1},
        {16'd4, 8'd1, 16'd3, 1'b0, 1'b0},
        {16'd0, 8'd1, 16'd0, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_wr_en = 1'b0;
    logic [1:0] sw_wr_addr = '0;
    logic [31:0] sw_wr_data = '0;
    logic svc_start = 1'b0, minor_done = 1'b0, eng_error = 1'b0;
    logic req_en, done, active, irq, link_start, desc_fetch, cfg_err;
    logic [ITER_W-1:0] citer;
    logic [5:0] link_ch;
    logic [PTR_W-1:0] desc_addr;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_major_ctl #(.ITER_W(ITER_W), .PTR_W(PTR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_addr(sw_wr_addr),
        .sw_wr_data(sw_wr_data), .svc_start(svc_start), .minor_done(minor_done),
        .eng_error(eng_error), .req_en(req_en), .done(done), .active(active),
        .irq(irq), .citer(citer), .link_start(link_start), .link_ch(link_ch),
        .desc_fetch(desc_fetch), .desc_addr(desc_addr), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_addr = a; sw_wr_data = d;
        @(negedge clk);
        sw_wr_en = 1'b0;
    endtask

    task automatic pulse_minor();
        @(negedge clk); minor_done = 1'b1;
        @(negedge clk); minor_done = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); svc_start = 1'b1;
        @(negedge clk); svc_start = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 done", done, 0); chk("R1 active", active, 0);
        chk("R1 irq", irq, 0); chk("R1 req_en", req_en, 0);
        chk("R1 citer", citer, 0); chk("R1 link", link_start, 0);
        chk("R1 fetch", desc_fetch, 0); chk("R1 err", cfg_err, 0);

        // Vector table: R3 counting and reload, R4 half-way interrupt
        for (int i = 0; i < NV; i++) begin
            sw_write(2'd3, 32'h7);
            sw_write(2'd0, 32'h1);
            sw_write(2'd1, {16'd0, VEC[i][41:26]});
            for (int k = 0; k < int'(VEC[i][25:18]); k++) pulse_minor();
            chk("R3 citer", citer, VEC[i][17:2]);
            chk("R3 done", done, VEC[i][1]);
            chk("R4 irq", irq, VEC[i][0]);
        end

        // R2: active handling, error does not count
        sw_write(2'd3, 32'h7);
        sw_write(2'd0, 32'h0);
        sw_write(2'd1, 32'd3);
        pulse_start();
        chk("R2 active set", active, 1);
        pulse_minor();
        chk("R2 active clr minor", active, 0);
        chk("R2 citer", citer, 2);
        pulse_start();
        @(negedge clk); minor_done = 1'b1; eng_error = 1'b1;
        @(negedge clk); minor_done = 1'b0; eng_error = 1'b0;
        chk("R2 active clr error", active, 0);
        chk("R2 citer held on error", citer, 2);
        pulse_minor(); pulse_minor();
        chk("R3 done at completion", done, 1);
        chk("R3 reload", citer, 3);
        pulse_start();
        chk("R2 start clears done", done, 0);

        // R10: command clears done
        pulse_minor(); pulse_minor(); pulse_minor();
        chk("R10 done before clear", done, 1);
        sw_write(2'd3, 32'h4);
        chk("R10 done cleared", done, 0);

        // R6: auto request disable
        sw_write(2'd3, 32'h7);
        sw_write(2'd0, 32'h24);
        sw_write(2'd1, 32'd1);
        chk("R6 req_en written", req_en, 1);
        pulse_minor();
        chk("R6 req_en cleared", req_en, 0);
        sw_write(2'd3, 32'h7);
        sw_write(2'd0, 32'h20);
        pulse_minor();
        chk("R6 req_en kept", req_en, 1);
        chk("R6 done", done, 1);

        // R7: link pulse
        sw_write(2'd3, 32'h7);
        sw_write(2'd0, 32'hA90);
        sw_write(2'd1, 32'd2);
        pulse_minor();
        chk("R7 no link early", link_start, 0);
        pulse_minor();
        chk("R7 link pulse", link_start, 1);
        chk("R7 link ch", link_ch, 42);
        @(negedge clk);
        chk("R7 link one cycle", link_start, 0);

        // R9: guarded enable write while done
        sw_write(2'd0, 32'hA90);
        sw_write(2'd3, 32'h4);
        sw_write(2'd1, 32'd1);
        pulse_minor();
        chk("R9 link forced off", link_start, 0);

        // R8: aligned fetch and misaligned error
        sw_write(2'd3, 32'h7);
        sw_write(2'd2, 32'h1000_0040);
        sw_write(2'd0, 32'h8);
        sw_write(2'd1, 32'd1);
        pulse_minor();
        chk("R8 fetch", desc_fetch, 1);
        chk("R8 addr", desc_addr, 32'h1000_0040);
        chk("R8 no err", cfg_err, 0);
        @(negedge clk);
        chk("R8 fetch one cycle", desc_fetch, 0);
        sw_write(2'd3, 32'h7);
        sw_write(2'd2, 32'h1000_0044);
        sw_write(2'd0, 32'h8);
        pulse_minor();
        chk("R8 misaligned no fetch", desc_fetch, 0);
        chk("R8 misaligned err", cfg_err, 1);
        sw_write(2'd3, 32'h2);
        chk("R8 err cleared", cfg_err, 0);

        // R5: completion interrupt, sticky
        sw_write(2'd3, 32'h7);
        sw_write(2'd0, 32'h2);
        sw_write(2'd1, 32'd2);
        pulse_minor();
        chk("R5 no irq mid", irq, 0);
        pulse_minor();
        chk("R5 irq at completion", irq, 1);
        repeat (5) @(negedge clk);
        chk("R5 irq sticky", irq, 1);
        sw_write(2'd3, 32'h2);
        chk("R5 irq kept by other bit", irq, 1);
        sw_write(2'd3, 32'h1);
        chk("R5 irq cleared", irq, 0);

        finish_run();
    end
endmodule